// File: doc/BRIEF.md
# Quadrature IQ Imbalance Corrector

This block cleans up a complex baseband sample stream that arrives as two 16-bit rails, in-phase (I) and quadrature (Q). It makes three corrections in a fixed order:

- It subtracts a DC offset from each rail.
- It fixes the phase skew by adding a scaled copy of Q into I.
- It fixes the gain mismatch by adding a scaled copy of Q back into Q.

Each correction has its own mode bit. When the bit is set, the block uses a value it estimates from the data. When the bit is clear, it uses the value the host has placed on its register input. The value in force can always be read on a readback output.

The block sits between the converter capture logic and the downstream digital signal chain. When the stream carries real rather than complex samples, a single mode input turns the block into a plain three-cycle delay line.

Top module: `iq_corrector`

## Requirements
- R1: `valid_o` is high exactly three clock cycles after `valid_i` was sampled high, and `i_dat_o`/`q_dat_o` carry the result of that sample.
- R2: In complex mode, the stage-one values are I' = sat(I − dcI) and Q' = sat(Q − dcQ). All values are 16-bit two's complement. When `ctrl_i[0]` is 0, dcI and dcQ come from `dc_i_reg_i` and `dc_q_reg_i`.
- R3: The phase output is I_out = sat(I' + rnd(Q'·c/2^13)). The coefficient c is bits 13:0 of the phase register taken as signed Q1.13, so bits 15:14 are ignored. When `ctrl_i[1]` is 0, c comes from `ph_reg_i`.
- R4: The gain output is Q_out = sat(Q' + rnd(Q'·a/2^13)). The coefficient a is bits 13:0 of `amp_reg_i` taken as signed Q1.13. It is used when `ctrl_i[2]` is 0.
- R5: rnd() rounds to the nearest integer, and a value exactly halfway is rounded toward +infinity. For example, 1.5 becomes 2 and −1.5 becomes −1.
- R6: Every subtraction and every sum saturates to the range [−32768, 32767] instead of wrapping.
- R7: When `cplx_i` is 0 (real mode), the outputs equal the inputs delayed by three cycles. All control and register inputs are ignored in this mode.
- R8: When `ctrl_i[0]` is 1, each DC value is a leaky mean m += (x − m)/2^10 of that raw rail. The mean is updated only on valid complex samples and holds otherwise.
- R9: When `ctrl_i[1]` is 1, c moves by 2 LSB after each valid complex output. It decreases when I_out·Q_out > 0 and increases when I_out·Q_out < 0. It is clamped to [−8192, 8191].
- R10: When `ctrl_i[2]` is 1, a moves by 2 LSB after each valid complex output. It decreases when |Q_out| > |I_out| and increases when |Q_out| < |I_out|. It is clamped to [−8192, 8191].
- R11: After reset, `valid_o` and both data outputs are 0, and all three estimates are 0.
- R12: The readback outputs show the value in force for each correction. That is the estimate when the correction's mode bit is 1, and the host value otherwise. Coefficients are sign-extended from bit 13 to 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample strobe |
| cplx_i | input | 1 | 1 = complex I/Q stream, 0 = real pass-through |
| ctrl_i | input | 3 | Auto bits: [0] DC, [1] phase, [2] gain |
| i_dat_i | input | 16 | In-phase sample |
| q_dat_i | input | 16 | Quadrature sample |
| dc_i_reg_i | input | 16 | Host DC offset for I |
| dc_q_reg_i | input | 16 | Host DC offset for Q |
| ph_reg_i | input | 16 | Host phase coefficient (bits 13:0 used) |
| amp_reg_i | input | 16 | Host gain coefficient (bits 13:0 used) |
| valid_o | output | 1 | Output sample strobe |
| i_dat_o | output | 16 | Corrected in-phase sample |
| q_dat_o | output | 16 | Corrected quadrature sample |
| dc_i_o | output | 16 | DC value for I in force |
| dc_q_o | output | 16 | DC value for Q in force |
| ph_coef_o | output | 16 | Phase coefficient in force, sign-extended |
| amp_coef_o | output | 16 | Gain coefficient in force, sign-extended |

## Verification
The assertions watch, on every cycle, the properties that do not depend on the data values:
- the three-cycle valid latency and the exact pass-through in real mode;
- that both adaptive coefficients never move by more than one 2-LSB step per cycle;
- that the DC estimates hold when no sample arrives;
- that readback coefficients stay inside the 14-bit signed range.

Only the bench scenarios can show the arithmetic: rounding at the half-LSB points, saturation at both rails, and the ignored upper coefficient bits. The same holds for where each estimator settles. The bench drives a constant DC offset until the mean locks, and drives a correlated I/Q pair and an unequal-amplitude pair with spaced samples until each loop parks at its predicted coefficient.

// File: rtl/iq_corr_pkg.sv
package iq_corr_pkg;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned COEF_W  = 14;
  localparam int unsigned DC_SH   = 10;
  localparam int unsigned LMS_MU  = 2;

  typedef enum logic [1:0] {
    CTL_DC  = 2'd0,
    CTL_PH  = 2'd1,
    CTL_AMP = 2'd2
  } ctl_bit_e;
endpackage

// File: rtl/iq_dc_est.sv
module iq_dc_est #(
  parameter int unsigned DW = 16,
  parameter int unsigned SH = 10
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 upd_i,
  input  logic signed [DW-1:0] x_i,
  output logic signed [DW-1:0] est_o
);
  localparam int unsigned AW = DW + SH;

  logic signed [AW-1:0] acc_q;
  logic signed [AW:0]   nxt;

  always_comb nxt = (AW+1)'(acc_q) + (AW+1)'(x_i) - (AW+1)'(acc_q >>> SH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (upd_i) acc_q <= nxt[AW-1:0];
  end

  assign est_o = acc_q[AW-1:SH];
endmodule

// File: rtl/iq_lms_est.sv
module iq_lms_est #(
  parameter int unsigned DW   = 16,
  parameter int unsigned CW   = 14,
  parameter int unsigned STEP = 2,
  parameter bit          AMP  = 1'b0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 upd_i,
  input  logic signed [DW-1:0] i_i,
  input  logic signed [DW-1:0] q_i,
  output logic signed [CW-1:0] est_o
);
  localparam logic signed [CW:0] MAXV = (CW+1)'(2**(CW-1) - 1);
  localparam logic signed [CW:0] MINV = (CW+1)'(-(2**(CW-1)));
  localparam logic signed [CW:0] MU   = (CW+1)'(STEP);

  logic pos, neg;

  generate
    if (AMP) begin : g_amp
      logic signed [DW:0]   ei, eq, mi, mq;
      logic signed [DW+1:0] df;
      always_comb begin
        ei = (DW+1)'(i_i);
        eq = (DW+1)'(q_i);
        mi = ei[DW] ? -ei : ei;
        mq = eq[DW] ? -eq : eq;
        df = (DW+2)'(mq) - (DW+2)'(mi);
      end
      assign pos = (df > 0);
      assign neg = (df < 0);
    end else begin : g_ph
      logic nz;
      assign nz  = (i_i != '0) && (q_i != '0);
      assign pos = nz && (i_i[DW-1] == q_i[DW-1]);
      assign neg = nz && (i_i[DW-1] != q_i[DW-1]);
    end
  endgenerate

  logic signed [CW:0] cur, nxt;
  always_comb begin
    cur = (CW+1)'(est_o);
    nxt = cur;
    if (pos)      nxt = cur - MU;
    else if (neg) nxt = cur + MU;
    if (nxt > MAXV) nxt = MAXV;
    if (nxt < MINV) nxt = MINV;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    est_o <= '0;
    else if (upd_i) est_o <= nxt[CW-1:0];
  end
endmodule

// File: rtl/iq_corr_dp.sv
module iq_corr_dp #(
  parameter int unsigned DW = 16,
  parameter int unsigned CW = 14
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic                 cplx_i,
  input  logic signed [DW-1:0] i_i,
  input  logic signed [DW-1:0] q_i,
  input  logic signed [DW-1:0] dc_i_i,
  input  logic signed [DW-1:0] dc_q_i,
  input  logic signed [CW-1:0] ph_c_i,
  input  logic signed [CW-1:0] amp_c_i,
  output logic                 valid_o,
  output logic                 cplx_o,
  output logic signed [DW-1:0] i_o,
  output logic signed [DW-1:0] q_o
);
  localparam int unsigned FRAC = CW - 1;
  localparam int unsigned PW   = DW + CW;
  localparam int unsigned SW   = DW + 2;
  localparam logic signed [PW-1:0] HALF = PW'(2**(FRAC-1));

  function automatic logic signed [DW-1:0] sat(input logic signed [SW-1:0] x);
    if (&x[SW-1:DW-1] || ~|x[SW-1:DW-1]) return x[DW-1:0];
    return x[SW-1] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
  endfunction

  // stage 1: offset removal
  logic                 v1, c1;
  logic signed [DW-1:0] a1, b1;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1 <= 1'b0; c1 <= 1'b0; a1 <= '0; b1 <= '0;
    end else begin
      v1 <= valid_i;
      c1 <= cplx_i;
      a1 <= cplx_i ? sat(SW'(i_i) - SW'(dc_i_i)) : i_i;
      b1 <= cplx_i ? sat(SW'(q_i) - SW'(dc_q_i)) : q_i;
    end
  end

  // stage 2: cross products, round half up
  logic signed [PW-1:0] pr_ph, pr_amp, rn_ph, rn_amp;
  always_comb begin
    pr_ph  = PW'(b1) * PW'(ph_c_i);
    pr_amp = PW'(b1) * PW'(amp_c_i);
    rn_ph  = (pr_ph + HALF) >>> FRAC;
    rn_amp = (pr_amp + HALF) >>> FRAC;
  end

  logic                 v2, c2;
  logic signed [DW-1:0] a2, b2;
  logic signed [SW-1:0] p2_ph, p2_amp;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v2 <= 1'b0; c2 <= 1'b0; a2 <= '0; b2 <= '0; p2_ph <= '0; p2_amp <= '0;
    end else begin
      v2     <= v1;
      c2     <= c1;
      a2     <= a1;
      b2     <= b1;
      p2_ph  <= c1 ? rn_ph[SW-1:0]  : '0;
      p2_amp <= c1 ? rn_amp[SW-1:0] : '0;
    end
  end

  // stage 3: accumulate and clip
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0; cplx_o <= 1'b0; i_o <= '0; q_o <= '0;
    end else begin
      valid_o <= v2;
      cplx_o  <= c2;
      i_o     <= sat(SW'(a2) + p2_ph);
      q_o     <= sat(SW'(b2) + p2_amp);
    end
  end
endmodule

// File: rtl/iq_corrector.sv
module iq_corrector
  import iq_corr_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned CW = COEF_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          cplx_i,
  input  logic [2:0]    ctrl_i,
  input  logic [DW-1:0] i_dat_i,
  input  logic [DW-1:0] q_dat_i,
  input  logic [DW-1:0] dc_i_reg_i,
  input  logic [DW-1:0] dc_q_reg_i,
  input  logic [DW-1:0] ph_reg_i,
  input  logic [DW-1:0] amp_reg_i,
  output logic          valid_o,
  output logic [DW-1:0] i_dat_o,
  output logic [DW-1:0] q_dat_o,
  output logic [DW-1:0] dc_i_o,
  output logic [DW-1:0] dc_q_o,
  output logic [DW-1:0] ph_coef_o,
  output logic [DW-1:0] amp_coef_o
);
  logic auto_dc, auto_ph, auto_amp;
  assign auto_dc  = ctrl_i[CTL_DC];
  assign auto_ph  = ctrl_i[CTL_PH];
  assign auto_amp = ctrl_i[CTL_AMP];

  logic unused_hi;
  assign unused_hi = ^{ph_reg_i[DW-1:CW], amp_reg_i[DW-1:CW]};

  logic signed [DW-1:0] est_dc_i, est_dc_q, dc_i_eff, dc_q_eff, i_cor, q_cor;
  logic signed [CW-1:0] est_ph, est_amp, ph_eff, amp_eff;
  logic                 cplx_s3, dc_upd, lms_upd;

  assign dc_upd  = valid_i && cplx_i && auto_dc;
  assign lms_upd = valid_o && cplx_s3;

  iq_dc_est #(.DW(DW), .SH(DC_SH)) u_dc_i (
    .clk_i, .rst_ni, .upd_i(dc_upd), .x_i(i_dat_i), .est_o(est_dc_i));
  iq_dc_est #(.DW(DW), .SH(DC_SH)) u_dc_q (
    .clk_i, .rst_ni, .upd_i(dc_upd), .x_i(q_dat_i), .est_o(est_dc_q));

  iq_lms_est #(.DW(DW), .CW(CW), .STEP(LMS_MU), .AMP(1'b0)) u_ph_est (
    .clk_i, .rst_ni, .upd_i(lms_upd && auto_ph),
    .i_i(i_cor), .q_i(q_cor), .est_o(est_ph));
  iq_lms_est #(.DW(DW), .CW(CW), .STEP(LMS_MU), .AMP(1'b1)) u_amp_est (
    .clk_i, .rst_ni, .upd_i(lms_upd && auto_amp),
    .i_i(i_cor), .q_i(q_cor), .est_o(est_amp));

  assign dc_i_eff = auto_dc  ? est_dc_i : dc_i_reg_i;
  assign dc_q_eff = auto_dc  ? est_dc_q : dc_q_reg_i;
  assign ph_eff   = auto_ph  ? est_ph   : ph_reg_i[CW-1:0];
  assign amp_eff  = auto_amp ? est_amp  : amp_reg_i[CW-1:0];

  iq_corr_dp #(.DW(DW), .CW(CW)) u_dp (
    .clk_i, .rst_ni, .valid_i, .cplx_i,
    .i_i(i_dat_i), .q_i(q_dat_i),
    .dc_i_i(dc_i_eff), .dc_q_i(dc_q_eff),
    .ph_c_i(ph_eff), .amp_c_i(amp_eff),
    .valid_o, .cplx_o(cplx_s3), .i_o(i_cor), .q_o(q_cor));

  assign i_dat_o    = i_cor;
  assign q_dat_o    = q_cor;
  assign dc_i_o     = dc_i_eff;
  assign dc_q_o     = dc_q_eff;
  assign ph_coef_o  = {{(DW-CW){ph_eff[CW-1]}}, ph_eff};
  assign amp_coef_o = {{(DW-CW){amp_eff[CW-1]}}, amp_eff};
endmodule

// File: rtl/iq_corrector_chk.sv
module iq_corrector_chk #(
  parameter int unsigned DW = 16,
  parameter int unsigned CW = 14
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic          cplx_i,
  input logic [2:0]    ctrl_i,
  input logic [DW-1:0] i_dat_i,
  input logic [DW-1:0] q_dat_i,
  input logic          valid_o,
  input logic [DW-1:0] i_dat_o,
  input logic [DW-1:0] q_dat_o,
  input logic [DW-1:0] dc_i_o,
  input logic [DW-1:0] dc_q_o,
  input logic [DW-1:0] ph_coef_o,
  input logic [DW-1:0] amp_coef_o
);
  logic [2:0]    v_d, c_d;
  logic [DW-1:0] i_d [3];
  logic [DW-1:0] q_d [3];
  logic [1:0]    age;
  logic          prev_v, prev_dc, prev_ph, prev_amp;
  logic [DW-1:0] prev_dci, prev_dcq, prev_phc, prev_ampc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_d <= '0; c_d <= '0; age <= '0;
      for (int k = 0; k < 3; k++) begin i_d[k] <= '0; q_d[k] <= '0; end
      prev_v <= 1'b0; prev_dc <= 1'b0; prev_ph <= 1'b0; prev_amp <= 1'b0;
      prev_dci <= '0; prev_dcq <= '0; prev_phc <= '0; prev_ampc <= '0;
    end else begin
      v_d <= {v_d[1:0], valid_i};
      c_d <= {c_d[1:0], cplx_i};
      i_d[0] <= i_dat_i; i_d[1] <= i_d[0]; i_d[2] <= i_d[1];
      q_d[0] <= q_dat_i; q_d[1] <= q_d[0]; q_d[2] <= q_d[1];
      if (age != 2'd3) age <= age + 2'd1;
      prev_v   <= valid_i;
      prev_dc  <= ctrl_i[0];
      prev_ph  <= ctrl_i[1];
      prev_amp <= ctrl_i[2];
      prev_dci <= dc_i_o;  prev_dcq  <= dc_q_o;
      prev_phc <= ph_coef_o; prev_ampc <= amp_coef_o;
    end
  end

  logic signed [DW:0] d_ph, d_amp;
  assign d_ph  = (DW+1)'($signed(ph_coef_o))  - (DW+1)'($signed(prev_phc));
  assign d_amp = (DW+1)'($signed(amp_coef_o)) - (DW+1)'($signed(prev_ampc));

  a_r1_valid_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age == 2'd3) |-> (valid_o == v_d[2]));

  a_r7_real_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age == 2'd3 && v_d[2] && !c_d[2]) |-> (i_dat_o == i_d[2] && q_dat_o == q_d[2]));

  a_r8_dc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[0] && prev_dc && !prev_v) |-> (dc_i_o == prev_dci && dc_q_o == prev_dcq));

  a_r9_ph_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[1] && prev_ph) |-> (d_ph >= -2 && d_ph <= 2));

  a_r10_amp_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[2] && prev_amp) |-> (d_amp >= -2 && d_amp <= 2));

  a_r12_coef_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&ph_coef_o[DW-1:CW-1] || ~|ph_coef_o[DW-1:CW-1]) &&
    (&amp_coef_o[DW-1:CW-1] || ~|amp_coef_o[DW-1:CW-1]));
endmodule

bind iq_corrector iq_corrector_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .cplx_i(cplx_i),
  .ctrl_i(ctrl_i), .i_dat_i(i_dat_i), .q_dat_i(q_dat_i),
  .valid_o(valid_o), .i_dat_o(i_dat_o), .q_dat_o(q_dat_o),
  .dc_i_o(dc_i_o), .dc_q_o(dc_q_o), .ph_coef_o(ph_coef_o),
  .amp_coef_o(amp_coef_o));

// File: tb/iq_corrector_tb.sv
`timescale 1ns/1ps
module iq_corrector_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0, cplx_i = 1'b1;
  logic [2:0]  ctrl_i = 3'b111;
  logic [15:0] i_in = '0, q_in = '0, dci = 16'h0011, dcq = 16'h0022;
  logic [15:0] phr = 16'h0033, ampr = 16'h0044;
  logic        valid_o;
  logic [15:0] i_out, q_out, dci_o, dcq_o, ph_o, amp_o;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  iq_corrector u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .cplx_i(cplx_i),
    .ctrl_i(ctrl_i), .i_dat_i(i_in), .q_dat_i(q_in),
    .dc_i_reg_i(dci), .dc_q_reg_i(dcq), .ph_reg_i(phr), .amp_reg_i(ampr),
    .valid_o(valid_o), .i_dat_o(i_out), .q_dat_o(q_out),
    .dc_i_o(dci_o), .dc_q_o(dcq_o), .ph_coef_o(ph_o), .amp_coef_o(amp_o));

  // {i, q, dcI, dcQ, ph, amp, exp_i, exp_q}
  localparam logic [127:0] VEC [11] = '{
    {16'h03E8, 16'h07D0, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h03E8, 16'h07D0}, // R2 identity
    {16'h03E8, 16'h07D0, 16'h0064, 16'hFF38, 16'h0000, 16'h0000, 16'h0384, 16'h0898}, // R2 offsets
    {16'h0000, 16'h03E8, 16'h0000, 16'h0000, 16'h1000, 16'h0000, 16'h01F4, 16'h03E8}, // R3 +0.5
    {16'h0000, 16'h03E8, 16'h0000, 16'h0000, 16'h0000, 16'h3000, 16'h0000, 16'h01F4}, // R4 -0.5
    {16'h7FFF, 16'h7FFF, 16'h0000, 16'h0000, 16'h1000, 16'h0000, 16'h7FFF, 16'h7FFF}, // R6 top
    {16'h8000, 16'h8000, 16'h0000, 16'h0000, 16'h1000, 16'h0000, 16'h8000, 16'h8000}, // R6 bottom
    {16'h8000, 16'h0000, 16'h0001, 16'h0000, 16'h0000, 16'h0000, 16'h8000, 16'h0000}, // R6 subtract
    {16'h0000, 16'h0003, 16'h0000, 16'h0000, 16'h1000, 16'h0000, 16'h0002, 16'h0003}, // R5 +1.5
    {16'h0000, 16'hFFFD, 16'h0000, 16'h0000, 16'h1000, 16'h0000, 16'hFFFF, 16'hFFFD}, // R5 -1.5
    {16'h0000, 16'h03E8, 16'h0000, 16'h0000, 16'hD000, 16'h0000, 16'h01F4, 16'h03E8}, // R3 upper bits
    {16'h0100, 16'h0200, 16'h0080, 16'hFF00, 16'h1000, 16'h1000, 16'h0200, 16'h0480}  // R4 combined
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one sample, checks valid timing (R1) and the result
  task automatic run_one(input logic [15:0] ii, input logic [15:0] qq,
                         input logic [15:0] ei, input logic [15:0] eq, input string tag);
    @(negedge clk); i_in = ii; q_in = qq; valid_i = 1'b1;
    @(negedge clk); valid_i = 1'b0;
    @(negedge clk); chk({"R1 early valid ", tag}, valid_o, 0);
    @(negedge clk);
    chk({"R1 valid ", tag}, valid_o, 1);
    chk({tag, " i"}, i_out, ei);
    chk({tag, " q"}, q_out, eq);
  endtask

  task automatic send_spaced(input logic [15:0] ii, input logic [15:0] qq, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); i_in = ii; q_in = qq; valid_i = 1'b1;
      @(negedge clk); valid_i = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state, estimates in force with all auto bits set
    chk("R11 valid_o", valid_o, 0);
    chk("R11 i_out", i_out, 0);
    chk("R11 q_out", q_out, 0);
    chk("R11 dc_i est", dci_o, 0);
    chk("R11 ph est", ph_o, 0);
    chk("R11 amp est", amp_o, 0);

    // host-value table
    ctrl_i = 3'b000;
    for (int v = 0; v < 11; v++) begin
      {dci, dcq, phr, ampr} = VEC[v][95:32];
      run_one(VEC[v][127:112], VEC[v][111:96], VEC[v][31:16], VEC[v][15:0],
              $sformatf("R2/R3/R4/R5/R6 vec %0d", v));
    end

    // R12 host readback, coefficient sign extension from bit 13
    dci = 16'h1234; dcq = 16'hFEDC; phr = 16'hC123; ampr = 16'h2001;
    @(negedge clk);
    chk("R12 dc_i host", dci_o, 16'h1234);
    chk("R12 dc_q host", dcq_o, 16'hFEDC);
    chk("R12 ph host", ph_o, 16'h0123);
    chk("R12 amp host", amp_o, 16'hE001);

    // R7 real mode pass-through with every correction armed
    cplx_i = 1'b0; ctrl_i = 3'b111; dci = 16'h0100; phr = 16'h1000; ampr = 16'h1000;
    run_one(16'h04D2, 16'hFFB3, 16'h04D2, 16'hFFB3, "R7 real");
    run_one(16'h8000, 16'h7FFF, 16'h8000, 16'h7FFF, "R7 real rails");
    cplx_i = 1'b1;

    // R8 estimate frozen while no valid sample
    ctrl_i = 3'b001; phr = 16'h0000; ampr = 16'h0000;
    i_in = 16'd5000; q_in = 16'd5000;
    repeat (50) @(negedge clk);
    chk("R8 no update without valid", dci_o, 0);

    // R8 mean locks onto constant offset
    i_in = 16'd1024; q_in = 16'hFE00;
    valid_i = 1'b1;
    repeat (10000) @(negedge clk);
    valid_i = 1'b0;
    repeat (4) @(negedge clk);
    chk("R8 dc_i est", dci_o, 16'd1024);
    chk("R8 dc_q est", dcq_o, 16'hFE00);
    run_one(16'd1024, 16'hFE00, 16'h0000, 16'h0000, "R8 corrected");

    // R9 phase loop, I=Q=1000, parks at -8188 (0xE004)
    ctrl_i = 3'b010; dci = 16'h0000; dcq = 16'h0000;
    send_spaced(16'd1000, 16'd1000, 4300);
    chk("R9 ph est", ph_o, 16'hE004);
    run_one(16'd1000, 16'd1000, 16'h0000, 16'd1000, "R9 corrected");

    // R10 gain loop, I=1000 Q=800, parks at 2044 (0x07FC)
    ctrl_i = 3'b100; phr = 16'h0000;
    send_spaced(16'd1000, 16'd800, 1200);
    chk("R10 amp est", amp_o, 16'h07FC);
    run_one(16'd1000, 16'd800, 16'd1000, 16'd1000, "R10 corrected");

    // R12 estimate readback gives way to host value when bit drops
    ctrl_i = 3'b000; ampr = 16'h0155;
    @(negedge clk);
    chk("R12 amp back to host", amp_o, 16'h0155);

    // R11 reset clears estimates
    rst_n = 1'b0; ctrl_i = 3'b111;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R11 dc_i after reset", dci_o, 0);
    chk("R11 ph after reset", ph_o, 0);
    chk("R11 amp after reset", amp_o, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule